// File: doc/BRIEF.md
# Half-Bridge Operator Control Sequencer

This block turns push-button presses into the operating mode of a half-bridge PWM stage. It takes single-cycle pulses from a Start/Stop button and a Sleep button, along with a six-bit option switch word. From these it drives a PWM enable, a sleep flag, an external pass-through flag and a one-cycle strobe that tells the PWM generator to latch its frequency and dead-time settings. It also drives four status lamps. The button pulses arrive already debounced.

After reset the lamps run a short chase, one lamp at a time. Button presses are accepted only once the chase is over. From then on the block holds one of four modes:
- stopped;
- running, with the RUN lamp blinking;
- asleep;
- external pass-through, in which an off-block controller drives the bridge and the internal input buffer is tri-stated.

A reserved switch word with every position on selects pass-through instead of internal PWM. The Sleep and Start buttons can each override the mode the other one set.

Top module: `bridge_opctl`

## Requirements
- R1: While reset is held, only lamp 0 is lit. After release, lamp i (i = 0..3) is lit alone for STEP_CYC cycles, in order from 0 to 3. All lamps are then dark for STEP_CYC more cycles. The chase ends 5*STEP_CYC cycles after release.
- R2: Start and Sleep pulses that arrive before the chase has ended have no effect on the mode, the strobe or the lamps.
- R3: A Start pulse while stopped, with a switch word that is not all ones (6'h3F), enters running. `pwm_en` goes high, and `cfg_capture` goes high for exactly that first running cycle.
- R4: A Start pulse while running returns to stopped. `pwm_en` goes low and lamp 0 goes dark.
- R5: While running, lamp 0 blinks with a 50% duty cycle and a half-period of BLINK_HALF cycles. The lamp is on for the first BLINK_HALF cycles after each entry into running.
- R6: A Start pulse while stopped or asleep, with switch word 6'h3F, enters external mode. `ext_mode` and lamp 3 go high, `pwm_en` stays low, and no strobe is issued.
- R7: In external mode a Start pulse returns to stopped and clears `ext_mode` and lamp 3. A Sleep pulse in external mode is ignored.
- R8: A Sleep pulse while stopped enters sleep, with `sleep_on` and lamp 1 high. A further Sleep pulse returns to stopped.
- R9: A Start pulse while asleep clears sleep and enters running, or external mode if the switch word is 6'h3F, exactly as from stopped.
- R10: A Sleep pulse while running stops the PWM and enters sleep: `pwm_en` low, lamp 0 dark, lamp 1 lit.
- R11: When Start and Sleep pulse in the same cycle, only the Start pulse takes effect.
- R12: Once the chase has ended, lamp 2 stays dark. The lamps then show {ext_mode, 0, sleep_on, RUN blink} on bits 3..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_p | input | 1 | Debounced Start/Stop press, one cycle per press |
| sleep_p | input | 1 | Debounced Sleep press, one cycle per press |
| opt_sw | input | SW_W | Option switch word; all ones selects pass-through |
| pwm_en | output | 1 | Internal PWM enabled |
| sleep_on | output | 1 | Sleep mode active |
| ext_mode | output | 1 | Pass-through active; tri-states the input buffer |
| cfg_capture | output | 1 | One-cycle strobe to latch the PWM settings |
| led | output | 4 | Status lamps: 0 RUN, 1 SLEEP, 2 unused, 3 EXTERNAL |

## Verification
The assertions assume that the button pulses and the switch word are synchronous to the clock. They also assume the switch word is valid in the cycle a Start pulse is sampled, so that the pass-through decision and the settings strobe refer to the same value. The stimulus changes every input only half a clock cycle away from the active edge. It holds each pulse for one cycle and sets the switch word in that same cycle. Presses come in bursts that sometimes coincide, which exercises the Start-over-Sleep rule. Presses are also sent during the chase, and a second reset is applied in the middle of operation.

// File: rtl/opctl_pkg.sv
package opctl_pkg;

  localparam int LAMP_N = 4;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_RUN   = 2'd1,
    M_SLEEP = 2'd2,
    M_EXT   = 2'd3
  } mode_t;

  // Reserved all-ones switch word selects pass-through.
  function automatic logic is_passthru(input logic [31:0] word, input int width);
    logic all1;
    all1 = 1'b1;
    for (int i = 0; i < width; i++) all1 = all1 & word[i];
    return all1;
  endfunction

  // Lamp word once the chase has finished.
  function automatic logic [LAMP_N-1:0] mode_lamps(input mode_t m, input logic blink);
    logic [LAMP_N-1:0] l;
    l = '0;
    l[0] = (m == M_RUN) && blink;
    l[1] = (m == M_SLEEP);
    l[3] = (m == M_EXT);
    return l;
  endfunction

endpackage

// File: rtl/opc_chase.sv
module opc_chase #(
  parameter int LAMP_N   = 4,
  parameter int STEP_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              done,
  output logic [LAMP_N-1:0] lamp_pat
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int IW = $clog2(LAMP_N + 1);

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          step_end;

  assign step_end = (cnt == CW'(STEP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      idx  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (step_end) begin
        cnt <= '0;
        if (idx == IW'(LAMP_N)) done <= 1'b1;
        else                    idx  <= idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < LAMP_N; i++) begin : g_lamp
    assign lamp_pat[i] = !done && (idx == IW'(i));
  end

  // R1: each step hands the lit lamp to the next one up
  p_chase_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && step_end && (idx < IW'(LAMP_N - 1))) |=> (lamp_pat == ($past(lamp_pat) << 1)));

  // R1: the dark step follows the last lamp
  p_chase_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && step_end && (idx == IW'(LAMP_N - 1))) |=> (lamp_pat == '0));

endmodule

// File: rtl/opc_blink.sv
module opc_blink #(
  parameter int BLINK_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic lamp
);
  localparam int BW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

  logic [BW-1:0] cnt;
  logic          half_end;

  assign half_end = (cnt == BW'(BLINK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      lamp <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      lamp <= 1'b1;
    end else if (active) begin
      if (half_end) begin
        cnt  <= '0;
        lamp <= ~lamp;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: blink restarts with the lamp on
  p_blink_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> lamp);

  // R5: the lamp holds within a half-period
  p_blink_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart && !half_end) |=> $stable(lamp));

endmodule

// File: rtl/opc_mode.sv
module opc_mode
  import opctl_pkg::*;
#(
  parameter int SW_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            start_p,
  input  logic            sleep_p,
  input  logic [SW_W-1:0] opt_sw,
  output mode_t           mode,
  output logic            run_start,
  output logic            cap_q
);
  logic  passthru;
  logic  start_ok;
  logic  sleep_ok;
  logic  from_rest;
  mode_t mode_nx;

  assign passthru  = is_passthru(32'(opt_sw), SW_W);
  assign start_ok  = accept && start_p;
  assign sleep_ok  = accept && sleep_p && !start_p;
  assign from_rest = (mode == M_IDLE) || (mode == M_SLEEP);
  assign run_start = start_ok && from_rest && !passthru;

  always_comb begin
    mode_nx = mode;
    if (start_ok) begin
      if (from_rest) mode_nx = passthru ? M_EXT : M_RUN;
      else           mode_nx = M_IDLE;
    end else if (sleep_ok) begin
      case (mode)
        M_IDLE:  mode_nx = M_SLEEP;
        M_SLEEP: mode_nx = M_IDLE;
        M_RUN:   mode_nx = M_SLEEP;
        default: mode_nx = mode;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_IDLE;
      cap_q <= 1'b0;
    end else begin
      mode  <= mode_nx;
      cap_q <= run_start;
    end
  end

  // R2: no mode change before the chase ends
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (mode == $past(mode)));

  // R6: pass-through is only entered on the reserved word
  p_ext_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_EXT) && ($past(mode) != M_EXT)) |-> is_passthru(32'($past(opt_sw)), SW_W));

  // R10: sleep press stops a running bridge
  p_sleep_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sleep_p && !start_p && (mode == M_RUN)) |=> (mode == M_SLEEP));

  // R11: start wins over a simultaneous sleep press
  p_start_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && start_p && sleep_p && (mode == M_RUN)) |=> (mode == M_IDLE));

  // R7: sleep press ignored in pass-through
  p_ext_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sleep_p && !start_p && (mode == M_EXT)) |=> (mode == M_EXT));

endmodule

// File: rtl/bridge_opctl.sv
module bridge_opctl
  import opctl_pkg::*;
#(
  parameter int STEP_CYC   = 32,
  parameter int BLINK_HALF = 10,
  parameter int SW_W       = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_p,
  input  logic            sleep_p,
  input  logic [SW_W-1:0] opt_sw,
  output logic            pwm_en,
  output logic            sleep_on,
  output logic            ext_mode,
  output logic            cfg_capture,
  output logic [3:0]      led
);
  logic              chase_done;
  logic [LAMP_N-1:0] chase_pat;
  mode_t             mode;
  logic              run_start;
  logic              cap_q;
  logic              blink_lamp;

  opc_chase #(.LAMP_N(LAMP_N), .STEP_CYC(STEP_CYC)) u_chase (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (chase_done),
    .lamp_pat (chase_pat)
  );

  opc_mode #(.SW_W(SW_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (chase_done),
    .start_p   (start_p),
    .sleep_p   (sleep_p),
    .opt_sw    (opt_sw),
    .mode      (mode),
    .run_start (run_start),
    .cap_q     (cap_q)
  );

  opc_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (run_start),
    .active  (mode == M_RUN),
    .lamp    (blink_lamp)
  );

  assign pwm_en      = (mode == M_RUN);
  assign sleep_on    = (mode == M_SLEEP);
  assign ext_mode    = (mode == M_EXT);
  assign cfg_capture = cap_q;
  assign led         = chase_done ? mode_lamps(mode, blink_lamp) : chase_pat;

  // R3: settings strobe only in the first running cycle
  p_capture_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_capture |-> (pwm_en && !$past(pwm_en)));

  // R5: RUN lamp on in the first running cycle
  p_run_lamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> led[0]);

  // R12: lamp 2 dark after the chase
  p_lamp2_dark_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chase_done |-> !led[2]);

  // R6: pass-through never leaves the internal PWM on
  p_ext_no_pwm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (!pwm_en && led[3] && !cfg_capture));

endmodule

// File: tb/bridge_opctl_tb.sv
module bridge_opctl_tb;
  localparam int S = 5;
  localparam int H = 3;
  localparam int MI = 0, MR = 1, MS = 2, MX = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_p = 1'b0;
  logic       sleep_p = 1'b0;
  logic [5:0] opt_sw = 6'd0;
  logic       pwm_en, sleep_on, ext_mode, cfg_capture;
  logic [3:0] led;

  int n_cmp = 0;
  int n_bad = 0;
  bit summary_done = 0;

  int e;
  int ms;
  bit mcap;
  int bcnt;
  bit bph;

  always #2.5 clk = ~clk;

  bridge_opctl #(.STEP_CYC(S), .BLINK_HALF(H), .SW_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .sleep_p(sleep_p),
    .opt_sw(opt_sw), .pwm_en(pwm_en), .sleep_on(sleep_on),
    .ext_mode(ext_mode), .cfg_capture(cfg_capture), .led(led)
  );

  function automatic logic [3:0] exp_led(int edges, int m, bit ph);
    if (edges < 4 * S) return 4'b0001 << (edges / S);
    if (edges < 5 * S) return 4'b0000;
    return {m == MX, 1'b0, m == MS, (m == MR) && ph};
  endfunction

  function automatic logic [7:0] exp_vec(int edges, int m, bit cap, bit ph);
    return {m == MR, m == MS, m == MX, cap, exp_led(edges, m, ph)};
  endfunction

  task automatic model_reset();
    e = 0; ms = MI; mcap = 0; bcnt = 0; bph = 0;
  endtask

  task automatic model_step(input bit st, input bit sl, input logic [5:0] op);
    bit acc;
    acc = (e >= 5 * S);
    e++;
    mcap = 0;
    if (acc && st) begin
      if (ms == MI || ms == MS) begin
        if (op == 6'h3F) ms = MX;
        else begin ms = MR; mcap = 1; bcnt = 0; bph = 1; end
      end else ms = MI;
    end else begin
      if (ms == MR) begin
        if (bcnt == H - 1) begin bcnt = 0; bph = ~bph; end
        else bcnt++;
      end
      if (acc && sl) begin
        if (ms == MI) ms = MS;
        else if (ms == MS) ms = MI;
        else if (ms == MR) ms = MS;
      end
    end
  endtask

  task automatic check(input string tag);
    logic [7:0] got, exp;
    got = {pwm_en, sleep_on, ext_mode, cfg_capture, led};
    exp = exp_vec(e, ms, mcap, bph);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s edge %0d: got %b expected %b", tag, e, got, exp);
    end
  endtask

  task automatic cycle(input bit st, input bit sl, input logic [5:0] op, input string tag);
    start_p = st; sleep_p = sl; opt_sw = op;
    @(negedge clk);
    model_step(st, sl, op);
    check(tag);
    start_p = 0; sleep_p = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(0, 0, 6'd0, tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 chase, R2 presses ignored during chase
    for (int i = 0; i < 5 * S; i++) begin
      if (i == 3) cycle(1, 0, 6'd5, "R2");
      else if (i == 9) cycle(0, 1, 6'd0, "R2");
      else if (i == 14) cycle(1, 1, 6'h3F, "R2");
      else cycle(0, 0, 6'd0, "R1");
    end
    idle(2, "R12");
    cycle(1, 0, 6'd3, "R3");
    idle(4 * H + 1, "R5");
    cycle(1, 0, 6'd0, "R4");
    idle(2, "R4");
    cycle(0, 1, 6'd0, "R8");
    idle(2, "R8");
    cycle(0, 1, 6'd0, "R8");
    idle(2, "R8");
    cycle(0, 1, 6'd0, "R9");
    cycle(1, 0, 6'd12, "R9");
    idle(H + 1, "R5");
    cycle(0, 1, 6'd0, "R10");
    idle(2, "R10");
    cycle(1, 0, 6'h3F, "R9");
    idle(2, "R6");
    cycle(0, 1, 6'd0, "R7");
    idle(2, "R7");
    cycle(1, 0, 6'd0, "R7");
    idle(2, "R7");
    cycle(1, 0, 6'h3F, "R6");
    cycle(1, 0, 6'd1, "R7");
    cycle(1, 0, 6'd7, "R3");
    cycle(1, 1, 6'd0, "R11");
    idle(2, "R11");
    cycle(1, 1, 6'd9, "R11");
    idle(2, "R11");
    for (int i = 0; i < 4000; i++) begin
      bit st, sl;
      logic [5:0] op;
      st = ($urandom % 7) == 0;
      sl = ($urandom % 9) == 0;
      op = (($urandom % 3) == 0) ? 6'h3F : 6'($urandom);
      cycle(st, sl, op, "RND");
    end
    // mid-operation reset
    cycle(1, 0, 6'd2, "R3");
    do_reset();
    for (int i = 0; i < 5 * S; i++) cycle(i == 7, 0, 6'd0, "R1");
    idle(3, "R12");
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

endmodule